// File: doc/BRIEF.md
# Dual-Core Lockstep Fault Manager with Self-Test

This block supervises two identical single-cycle processor cores that run side by side. In normal operation it forwards every instruction word from instruction memory to both cores. It compares the two result words on every cycle. The primary core's result and write request go on to data memory.

When the two results differ, the block switches to self-test. It feeds both cores a fixed set of stored test instructions for several passes and holds data-memory writes off. It checks each core's result against a stored expected value. At the end of the test it gives a verdict. The verdict sets three fault indicators and decides which core drives the system result from then on.

A verdict that names one or both cores stays in place until reset. A test that both cores pass is treated as a transient upset: the indicators clear and the block returns to normal service on the primary core.

Top module: `dual_core_fault_mgr`

## Requirements
- R1: After reset the block is in normal service with all three indicators off, `selftest_on` low and `use_backup` low (primary core selected).
- R2: In normal service both cores receive `imem_instr`. `sys_result` equals the primary core's result. `dmem_we` equals the primary core's write request.
- R3: In normal service, if the two core results differ on a cycle, then from the next clock edge `flt_any` is high and `selftest_on` is high.
- R4: Self-test applies vector k for k = 0..7 in ascending order, in 3 consecutive passes, one vector per cycle, for 24 cycles. Vector k is the word 0xA5C30F96 XOR the byte k replicated into all four bytes. Both core instruction ports carry that word. `dmem_we` is held low for the whole self-test, including the verdict cycle.
- R5: The expected result for each test vector is the bitwise inverse of the vector. A core whose result differs from the expected value in any single comparison, in any pass, is judged faulty.
- R6: One cycle after the last vector the verdict shows on the indicators. If only the primary core is faulty, `flt_any` and `flt_primary` are on. If only the backup core is faulty, `flt_any` and `flt_backup` are on. If both are faulty, all three are on.
- R7: With only the primary core faulty, `use_backup` goes high: `sys_result` and `dmem_we` then follow the backup core. With only the backup core faulty, they follow the primary core.
- R8: With both cores faulty, the block holds a maintenance state. In that state `dmem_we` stays low and no further self-test starts.
- R9: If neither core fails the self-test, all indicators clear, `use_backup` is low and normal service with mismatch detection resumes.
- R10: After a fault verdict, later result mismatches start no new self-test and do not change the indicators or `use_backup` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_instr | input | 32 | Instruction word from instruction memory |
| core_a_instr | output | 32 | Instruction to the primary core |
| core_b_instr | output | 32 | Instruction to the backup core |
| core_a_result | input | 32 | Result from the primary core |
| core_b_result | input | 32 | Result from the backup core |
| core_a_we | input | 1 | Data-memory write request from the primary core |
| core_b_we | input | 1 | Data-memory write request from the backup core |
| sys_result | output | 32 | Result of the selected core (data-memory write data) |
| dmem_we | output | 1 | Data-memory write enable |
| selftest_on | output | 1 | Self-test (or its verdict cycle) in progress |
| flt_any | output | 1 | A fault was detected |
| flt_primary | output | 1 | Primary core judged faulty |
| flt_backup | output | 1 | Backup core judged faulty |
| use_backup | output | 1 | System result taken from the backup core |

## Verification
A wrong vector counter or pass counter shows on the core instruction ports within one cycle of the slip. The verdict would then also arrive on the wrong cycle, so the bench checks the indicators exactly 25 edges after the triggering mismatch. A lost per-core fail flag shows up as a wrong indicator pattern or a wrong output core right at the verdict. The bench places single faults in early, middle and late passes to expose flags that fail to stick. A broken sticky state shows as a new self-test or changed indicators as soon as a later mismatch is driven.

// File: rtl/fm_pkg.sv
package fm_pkg;

   typedef enum logic [2:0] {
      ST_NORMAL   = 3'd0,
      ST_TEST     = 3'd1,
      ST_EVAL     = 3'd2,
      ST_DEGRADED = 3'd3,
      ST_BOTH     = 3'd4
   } fm_state_t;

   localparam int NCORE = 2;

endpackage

// File: rtl/fm_vector_rom.sv
module fm_vector_rom #(
   parameter int          DATA_W = 32,
   parameter int          DEPTH  = 8,
   parameter logic [31:0] SEED   = 32'hA5C3_0F96
) (
   input  logic [$clog2(DEPTH)-1:0] idx,
   output logic [DATA_W-1:0]        instr,
   output logic [DATA_W-1:0]        expect_res
);
   localparam int VEC_W = $clog2(DEPTH);
   localparam int NBYTE = DATA_W / 8;

   initial begin
      assert (DATA_W % 8 == 0 && DATA_W <= 32) else $error("DATA_W must be 8..32 in whole bytes");
      assert (DEPTH > 1 && DEPTH <= 256 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two up to 256");
   end

   logic [7:0] idx_byte;
   assign idx_byte = 8'(idx);

   always_comb begin
      instr = SEED[DATA_W-1:0];
      for (int b = 0; b < NBYTE; b++) begin
         instr[b*8 +: 8] = SEED[b*8 +: 8] ^ idx_byte;
      end
      expect_res = ~instr;
   end

   logic unused_w;
   assign unused_w = ^{VEC_W};
endmodule

// File: rtl/fm_self_check.sv
module fm_self_check
   import fm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         check_en,
   input  logic [NCORE-1:0][DATA_W-1:0] res,
   input  logic [DATA_W-1:0]            expect_res,
   output logic [NCORE-1:0]             fail
);
   for (genvar c = 0; c < NCORE; c++) begin : g_core
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            fail[c] <= 1'b0;
         end else if (check_en && (res[c] != expect_res)) begin
            fail[c] <= 1'b1;
         end
      end

      assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (fail[c] && !clear) |=> fail[c]);
   end
endmodule

// File: rtl/fm_sequencer.sv
module fm_sequencer
   import fm_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int PASSES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mismatch,
   input  logic [NCORE-1:0]         fail,
   output fm_state_t                state,
   output logic [$clog2(DEPTH)-1:0] vec_idx,
   output logic                     led_any,
   output logic                     led_pri,
   output logic                     led_bak,
   output logic                     sel_bak
);
   localparam int VEC_W  = $clog2(DEPTH);
   localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
   localparam logic [VEC_W-1:0]  VEC_LAST  = VEC_W'(DEPTH - 1);
   localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

   initial begin
      assert (PASSES >= 1) else $error("PASSES must be at least one");
   end

   logic [PASS_W-1:0] pass_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_NORMAL;
         vec_idx <= '0;
         pass_q  <= '0;
         led_any <= 1'b0;
         led_pri <= 1'b0;
         led_bak <= 1'b0;
         sel_bak <= 1'b0;
      end else begin
         case (state)
            ST_NORMAL: begin
               if (mismatch) begin
                  state   <= ST_TEST;
                  led_any <= 1'b1;
                  vec_idx <= '0;
                  pass_q  <= '0;
               end
            end
            ST_TEST: begin
               if (vec_idx == VEC_LAST) begin
                  vec_idx <= '0;
                  if (pass_q == PASS_LAST) begin
                     state <= ST_EVAL;
                  end else begin
                     pass_q <= pass_q + 1'b1;
                  end
               end else begin
                  vec_idx <= vec_idx + 1'b1;
               end
            end
            ST_EVAL: begin
               case (fail)
                  2'b00: begin
                     state   <= ST_NORMAL;
                     led_any <= 1'b0;
                     sel_bak <= 1'b0;
                  end
                  2'b01: begin
                     state   <= ST_DEGRADED;
                     led_pri <= 1'b1;
                     sel_bak <= 1'b1;
                  end
                  2'b10: begin
                     state   <= ST_DEGRADED;
                     led_bak <= 1'b1;
                     sel_bak <= 1'b0;
                  end
                  default: begin
                     state   <= ST_BOTH;
                     led_pri <= 1'b1;
                     led_bak <= 1'b1;
                     sel_bak <= 1'b0;
                  end
               endcase
            end
            default: state <= state;
         endcase
      end
   end

   assert_degraded_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEGRADED) |=> (state == ST_DEGRADED) && $stable(led_pri) && $stable(sel_bak));

   assert_maint_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BOTH) |=> (state == ST_BOTH) && led_pri && led_bak);
endmodule

// File: rtl/dual_core_fault_mgr.sv
module dual_core_fault_mgr
   import fm_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          DEPTH  = 8,
   parameter int          PASSES = 3,
   parameter logic [31:0] SEED   = 32'hA5C3_0F96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] imem_instr,
   output logic [DATA_W-1:0] core_a_instr,
   output logic [DATA_W-1:0] core_b_instr,
   input  logic [DATA_W-1:0] core_a_result,
   input  logic [DATA_W-1:0] core_b_result,
   input  logic              core_a_we,
   input  logic              core_b_we,
   output logic [DATA_W-1:0] sys_result,
   output logic              dmem_we,
   output logic              selftest_on,
   output logic              flt_any,
   output logic              flt_primary,
   output logic              flt_backup,
   output logic              use_backup
);
   localparam int VEC_W = $clog2(DEPTH);

   fm_state_t               state;
   logic [VEC_W-1:0]        vec_idx;
   logic [DATA_W-1:0]       rom_instr;
   logic [DATA_W-1:0]       rom_expect;
   logic [NCORE-1:0]        fail;
   logic                    mismatch;
   logic                    writes_ok;
   logic [DATA_W-1:0]       instr_mux;

   fm_vector_rom #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEED(SEED)) i_rom (
      .idx        (vec_idx),
      .instr      (rom_instr),
      .expect_res (rom_expect)
   );

   fm_self_check #(.DATA_W(DATA_W)) i_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state == ST_NORMAL),
      .check_en   (state == ST_TEST),
      .res        ({core_b_result, core_a_result}),
      .expect_res (rom_expect),
      .fail       (fail)
   );

   fm_sequencer #(.DEPTH(DEPTH), .PASSES(PASSES)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mismatch (mismatch),
      .fail     (fail),
      .state    (state),
      .vec_idx  (vec_idx),
      .led_any  (flt_any),
      .led_pri  (flt_primary),
      .led_bak  (flt_backup),
      .sel_bak  (use_backup)
   );

   assign mismatch     = (core_a_result != core_b_result);
   assign selftest_on  = (state == ST_TEST) || (state == ST_EVAL);
   assign instr_mux    = selftest_on ? rom_instr : imem_instr;
   assign core_a_instr = instr_mux;
   assign core_b_instr = instr_mux;
   assign writes_ok    = (state == ST_NORMAL) || (state == ST_DEGRADED);
   assign sys_result   = use_backup ? core_b_result : core_a_result;
   assign dmem_we      = writes_ok && (use_backup ? core_b_we : core_a_we);

   assert_mismatch_starts_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NORMAL && mismatch) |=> (flt_any && selftest_on));

   assert_no_write_in_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
      selftest_on |-> !dmem_we);

   assert_leds_imply_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_primary || flt_backup) |-> flt_any);

   assert_single_fault_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEGRADED) |-> ((flt_primary != flt_backup) && (use_backup == flt_primary)));
endmodule

// File: tb/test_dual_core_fault_mgr.sv
module test_dual_core_fault_mgr;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SEED = 32'hA5C3_0F96;
   localparam logic [31:0] MASK_A = 32'h0000_0100;
   localparam logic [31:0] MASK_B = 32'h8000_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] imem_instr = '0;
   logic [31:0] core_a_instr, core_b_instr, core_a_result, core_b_result, sys_result;
   logic core_a_we = 1'b0, core_b_we = 1'b0;
   logic dmem_we, selftest_on, flt_any, flt_primary, flt_backup, use_backup;
   logic inj_a = 1'b0, inj_b = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural cores: a healthy core returns the inverse of its instruction
   assign core_a_result = ~core_a_instr ^ (inj_a ? MASK_A : 32'h0);
   assign core_b_result = ~core_b_instr ^ (inj_b ? MASK_B : 32'h0);

   dual_core_fault_mgr i_dual_core_fault_mgr (
      .clk(clk), .rst_n(rst_n), .imem_instr(imem_instr),
      .core_a_instr(core_a_instr), .core_b_instr(core_b_instr),
      .core_a_result(core_a_result), .core_b_result(core_b_result),
      .core_a_we(core_a_we), .core_b_we(core_b_we),
      .sys_result(sys_result), .dmem_we(dmem_we), .selftest_on(selftest_on),
      .flt_any(flt_any), .flt_primary(flt_primary), .flt_backup(flt_backup),
      .use_backup(use_backup)
   );

   function automatic logic [31:0] vec_word(input int k);
      logic [7:0] kb = 8'(k);
      return SEED ^ {kb, kb, kb, kb};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; inj_a = 1'b0; inj_b = 1'b0;
      core_a_we = 1'b0; core_b_we = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic check_leds(input string req, input logic a, input logic p, input logic b, input logic s);
      chk({req, " flt_any"}, 32'(flt_any), 32'(a));
      chk({req, " flt_primary"}, 32'(flt_primary), 32'(p));
      chk({req, " flt_backup"}, 32'(flt_backup), 32'(b));
      chk({req, " use_backup"}, 32'(use_backup), 32'(s));
   endtask

   task automatic normal_run(input int n);
      for (int i = 0; i < n; i++) begin
         imem_instr = $urandom;
         core_a_we = 1'($urandom);
         core_b_we = core_a_we;
         #1;
         chk("R2 core_a_instr", core_a_instr, imem_instr);
         chk("R2 core_b_instr", core_b_instr, imem_instr);
         chk("R2 sys_result", sys_result, ~imem_instr);
         chk("R2 dmem_we", 32'(dmem_we), 32'(core_a_we));
         tick();
      end
   endtask

   // trigger a mismatch, run self-test with faults at (bad_pass, bad_vec)
   task automatic self_test(input bit a_bad, input bit b_bad, input int bad_pass, input int bad_vec);
      logic exp_any, exp_p, exp_b, exp_s;
      imem_instr = $urandom;
      core_a_we = 1'b1; core_b_we = 1'b1;
      inj_a = 1'b1;
      tick();
      inj_a = 1'b0;
      chk("R3 flt_any after mismatch", 32'(flt_any), 32'd1);
      chk("R3 selftest_on after mismatch", 32'(selftest_on), 32'd1);
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < 8; k++) begin
            chk("R4 test vector a", core_a_instr, vec_word(k));
            chk("R4 test vector b", core_b_instr, vec_word(k));
            chk("R4 dmem_we blocked", 32'(dmem_we), 32'd0);
            inj_a = a_bad && (p == bad_pass) && (k == bad_vec);
            inj_b = b_bad && (p == bad_pass) && (k == bad_vec);
            #1;
            tick();
         end
      end
      inj_a = 1'b0; inj_b = 1'b0;
      chk("R4 verdict cycle selftest_on", 32'(selftest_on), 32'd1);
      chk("R4 verdict cycle dmem_we", 32'(dmem_we), 32'd0);
      tick();
      exp_any = a_bad || b_bad;
      exp_p = a_bad;
      exp_b = b_bad;
      exp_s = a_bad && !b_bad;
      if (!exp_any) check_leds("R9 transient", 1'b0, 1'b0, 1'b0, 1'b0);
      else check_leds("R6 R5 verdict", exp_any, exp_p, exp_b, exp_s);
      chk("R6 selftest_on off", 32'(selftest_on), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      #1;
      check_leds("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 selftest_on", 32'(selftest_on), 32'd0);
      normal_run(60);

      // transient: both pass, back to normal with detection
      self_test(1'b0, 1'b0, 0, 0);
      normal_run(20);
      // R9 detection still armed
      self_test(1'b0, 1'b0, 1, 3);

      // primary faulty only in the last pass, late vector
      do_reset();
      self_test(1'b1, 1'b0, 2, 7);
      for (int i = 0; i < 10; i++) begin
         imem_instr = $urandom;
         core_a_we = 1'($urandom); core_b_we = 1'($urandom);
         inj_a = 1'($urandom);
         #1;
         chk("R7 sys_result from backup", sys_result, core_b_result);
         chk("R7 dmem_we from backup", 32'(dmem_we), 32'(core_b_we));
         chk("R2 imem to cores in degraded", core_a_instr, imem_instr);
         tick();
         chk("R10 no new test", 32'(selftest_on), 32'd0);
         check_leds("R10 sticky", 1'b1, 1'b1, 1'b0, 1'b1);
      end

      // backup faulty only in the first pass, first vector
      do_reset();
      self_test(1'b0, 1'b1, 0, 0);
      for (int i = 0; i < 10; i++) begin
         imem_instr = $urandom;
         core_a_we = 1'($urandom); core_b_we = 1'($urandom);
         inj_b = 1'($urandom);
         #1;
         chk("R7 sys_result from primary", sys_result, core_a_result);
         chk("R7 dmem_we from primary", 32'(dmem_we), 32'(core_a_we));
         tick();
         check_leds("R10 sticky backup", 1'b1, 1'b0, 1'b1, 1'b0);
      end

      // both faulty in the middle pass
      do_reset();
      self_test(1'b1, 1'b1, 1, 4);
      for (int i = 0; i < 10; i++) begin
         imem_instr = $urandom;
         core_a_we = 1'b1; core_b_we = 1'b1;
         inj_a = 1'($urandom);
         #1;
         chk("R8 writes blocked", 32'(dmem_we), 32'd0);
         tick();
         chk("R8 no new test", 32'(selftest_on), 32'd0);
         check_leds("R8 maintenance", 1'b1, 1'b1, 1'b1, 1'b0);
      end

      inj_a = 1'b0;
      do_reset();
      #1;
      check_leds("R1 reset clears", 1'b0, 1'b0, 1'b0, 1'b0);
      normal_run(20);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule